// File: doc/BRIEF.md
# CAN Driver Fault Guard

This block sits in a CAN transceiver's digital core, between the synchronised transmit line from the protocol controller and the enable of the bus driver. It passes a dominant request to the driver only when the device is in normal mode and no fault is active. In every other case the bus is left recessive. The temperature sensor and current limiting live elsewhere. This block sees only two digital flags from the thermal sensor: one that says the die is too hot, and one that says it has cooled below the recovery level.

Two faults are guarded, and they recover in different ways. If the transmit line is held low longer than a programmable number of clock cycles (in the millisecond range on silicon), a dominant-timeout fault stops the driver. This fault clears as soon as the transmit line is seen high again. An overtemperature flag stops the driver in the same cycle and latches a thermal-shutdown fault. That fault clears only when a transmit high-to-low transition is seen while the die is below the recovery level and the overtemperature flag is off. Cooling alone does not clear it. A falling edge while the die is still hot does not clear it either. Each fault has a sticky status output.

Top module: `can_drv_guard`

## Requirements
- R1: While rst_ni is low, dom_to_o and tsd_o are 0. With txd_i high, drv_dom_o is 0.
- R2: txd_i = 1 means recessive. Whenever txd_i is 1, drv_dom_o is 0. With norm_i = 1, no fault set and ovt_i = 0, drv_dom_o follows ~txd_i in the same cycle.
- R3: Whenever norm_i is 0, drv_dom_o is 0. While norm_i is 0, the timeout count is held at zero, so a low txd_i during that time counts nothing toward a timeout.
- R4: Take the cycles in which norm_i = 1 and txd_i = 0 at rising edges of clk_i. When TO_CYCLES of these occur in a row, dom_to_o is 1 after the last such edge, and drv_dom_o is 0 from then on.
- R5: The first rising edge that samples txd_i high clears dom_to_o and restarts the count. A new low period needs a full TO_CYCLES again, including after a one-cycle high glitch.
- R6: ovt_i = 1 forces drv_dom_o to 0 in the same cycle. It sets tsd_o at the next rising edge.
- R7: While cool_i is 0, tsd_o stays 1 once it is set, even if txd_i has falling edges.
- R8: tsd_o clears only at a rising edge that samples txd_i low after the previous edge sampled it high, with cool_i = 1 and ovt_i = 0. Cooling while txd_i stays steady does not clear it.
- R9: If ovt_i is 1 at the same edge as a valid recovery edge, tsd_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txd_i | input | 1 | Synchronised transmit request, 0 = dominant |
| ovt_i | input | 1 | Overtemperature flag from the sensor |
| cool_i | input | 1 | Die is below the recovery level (threshold minus hysteresis) |
| norm_i | input | 1 | Device is in normal mode |
| drv_dom_o | output | 1 | Driver command, 1 = drive dominant |
| dom_to_o | output | 1 | Sticky dominant-timeout fault |
| tsd_o | output | 1 | Sticky thermal-shutdown fault |

## Verification
drv_dom_o is combinational from the inputs and the two fault flags. So the bench checks it 1 ns after it changes an input at the falling clock edge, within the same cycle. Both status flags are registered and change at the first rising edge that samples the cause. The bench therefore advances exactly one edge and checks at the following falling edge. For the timeout it checks both sides of the boundary: the flag is still 0 after TO_CYCLES-1 low edges and is 1 after TO_CYCLES.

// File: rtl/can_guard_pkg.sv
package can_guard_pkg;
  typedef enum logic {
    TH_RUN  = 1'b0,
    TH_SHUT = 1'b1
  } th_state_e;
endpackage

// File: rtl/can_guard_edge.sv
module can_guard_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txd_i,
  output logic fall_o
);
  logic txd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) txd_q <= 1'b1;
    else         txd_q <= txd_i;
  end

  assign fall_o = txd_q & ~txd_i;
endmodule

// File: rtl/can_guard_dom_timer.sv
module can_guard_dom_timer #(
  parameter int unsigned TO_CYCLES = 125000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txd_i,
  input  logic norm_i,
  output logic to_o
);
  localparam int unsigned CNT_W = (TO_CYCLES < 2) ? 1 : $clog2(TO_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TO_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             to_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else if (txd_i) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else if (!norm_i) begin
      cnt_q <= '0;
    end else if (!to_q) begin
      if (cnt_q == LAST) to_q  <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign to_o = to_q;
endmodule

// File: rtl/can_guard_thermal.sv
module can_guard_thermal
  import can_guard_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovt_i,
  input  logic cool_i,
  input  logic fall_i,
  output logic tsd_o
);
  th_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TH_RUN:  if (ovt_i) state_d = TH_SHUT;
      TH_SHUT: if (!ovt_i && cool_i && fall_i) state_d = TH_RUN;
      default: state_d = TH_SHUT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= TH_RUN;
    else         state_q <= state_d;
  end

  assign tsd_o = (state_q == TH_SHUT);
endmodule

// File: rtl/can_drv_guard.sv
module can_drv_guard #(
  parameter int unsigned TO_CYCLES = 125000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txd_i,
  input  logic ovt_i,
  input  logic cool_i,
  input  logic norm_i,
  output logic drv_dom_o,
  output logic dom_to_o,
  output logic tsd_o
);
  logic fall;
  logic to_flag;
  logic tsd_flag;

  can_guard_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .txd_i  (txd_i),
    .fall_o (fall)
  );

  can_guard_dom_timer #(.TO_CYCLES(TO_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .txd_i  (txd_i),
    .norm_i (norm_i),
    .to_o   (to_flag)
  );

  can_guard_thermal u_thermal (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ovt_i  (ovt_i),
    .cool_i (cool_i),
    .fall_i (fall),
    .tsd_o  (tsd_flag)
  );

  // ovt_i gates directly so shutdown takes effect in the same cycle
  assign drv_dom_o = norm_i & ~txd_i & ~to_flag & ~tsd_flag & ~ovt_i;
  assign dom_to_o  = to_flag;
  assign tsd_o     = tsd_flag;
endmodule

// File: rtl/can_drv_guard_chk.sv
module can_drv_guard_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic txd_i,
  input logic ovt_i,
  input logic cool_i,
  input logic norm_i,
  input logic drv_dom_o,
  input logic dom_to_o,
  input logic tsd_o
);
  // R2
  txd_high_recessive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txd_i |-> !drv_dom_o);

  // R3
  standby_recessive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !norm_i |-> !drv_dom_o);

  // R5
  to_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txd_i |=> !dom_to_o);

  // R6
  ovt_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovt_i |=> tsd_o);

  // R6
  ovt_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovt_i |-> !drv_dom_o);

  // R7
  hot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tsd_o && !cool_i) |=> tsd_o);

  // R8
  no_edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tsd_o && txd_i) |=> tsd_o);

  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_clear_chk: assert (!dom_to_o && !tsd_o);
    end
  end
endmodule

bind can_drv_guard can_drv_guard_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .txd_i     (txd_i),
  .ovt_i     (ovt_i),
  .cool_i    (cool_i),
  .norm_i    (norm_i),
  .drv_dom_o (drv_dom_o),
  .dom_to_o  (dom_to_o),
  .tsd_o     (tsd_o)
);

// File: tb/can_drv_guard_test.sv
module can_drv_guard_test;
  localparam int TO = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txd = 1'b1;
  logic ovt = 1'b0;
  logic cool = 1'b1;
  logic norm = 1'b0;
  logic drv, dto, tsd;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  can_drv_guard #(.TO_CYCLES(TO)) uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .txd_i     (txd),
    .ovt_i     (ovt),
    .cool_i    (cool),
    .norm_i    (norm),
    .drv_dom_o (drv),
    .dom_to_o  (dto),
    .tsd_o     (tsd)
  );

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R1 drv in reset", drv, 1'b0);
    chk("R1 dom_to in reset", dto, 1'b0);
    chk("R1 tsd in reset", tsd, 1'b0);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic t_pass();
    norm = 1'b1; txd = 1'b0; #1;
    chk("R2 low passes dominant", drv, 1'b1);
    txd = 1'b1; #1;
    chk("R2 high recessive", drv, 1'b0);
    tick(1);
  endtask

  task automatic t_mode();
    norm = 1'b0; txd = 1'b0; #1;
    chk("R3 standby recessive", drv, 1'b0);
    tick(TO + 5);
    chk("R3 no timeout in standby", dto, 1'b0);
    norm = 1'b1; #1;
    chk("R3 normal dominant", drv, 1'b1);
    tick(TO - 1);
    chk("R4 no flag at TO-1", dto, 1'b0);
    chk("R4 still dominant at TO-1", drv, 1'b1);
    tick(1);
    chk("R4 flag at TO", dto, 1'b1);
    chk("R4 driver off", drv, 1'b0);
  endtask

  task automatic t_clear();
    txd = 1'b1; tick(1);
    chk("R5 cleared on high", dto, 1'b0);
    txd = 1'b0; #1;
    chk("R5 dominant after clear", drv, 1'b1);
    tick(TO - 5);
    txd = 1'b1; tick(1);
    txd = 1'b0; tick(TO - 1);
    chk("R5 glitch restarts count", dto, 1'b0);
    tick(1);
    chk("R5 full window after restart", dto, 1'b1);
    txd = 1'b1; tick(1);
    chk("R5 clear again", dto, 1'b0);
  endtask

  task automatic t_thermal();
    cool = 1'b0; txd = 1'b0; ovt = 1'b1; #1;
    chk("R6 same cycle block", drv, 1'b0);
    tick(1);
    chk("R6 tsd set", tsd, 1'b1);
    ovt = 1'b0; txd = 1'b1; tick(1);
    txd = 1'b0; tick(1);
    chk("R7 hot edge ignored", tsd, 1'b1);
    chk("R7 driver off while hot", drv, 1'b0);
    cool = 1'b1; tick(3);
    chk("R8 cooling alone no clear", tsd, 1'b1);
    txd = 1'b1; tick(1);
    chk("R8 still set with high", tsd, 1'b1);
    txd = 1'b0; tick(1);
    chk("R8 cleared by cool edge", tsd, 1'b0);
    chk("R8 driver back", drv, 1'b1);
    txd = 1'b1; tick(1);
  endtask

  task automatic t_prio();
    ovt = 1'b1; tick(1);
    chk("R6 set again", tsd, 1'b1);
    txd = 1'b0; cool = 1'b1; tick(1);
    chk("R9 ovt beats recovery", tsd, 1'b1);
    ovt = 1'b0; txd = 1'b1; tick(1);
    txd = 1'b0; tick(1);
    chk("R8 recovery after ovt off", tsd, 1'b0);
    txd = 1'b1; tick(1);
  endtask

  initial begin
    t_reset();
    t_pass();
    t_mode();
    t_clear();
    t_thermal();
    t_prio();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule